// File: doc/BRIEF.md
# Prioritised Interrupt Controller, 64 Sources

This block gathers up to 64 interrupt request lines and reduces them to one interrupt output for a processor. Each line passes through a synchroniser. It is then handled in one of two ways. A level source counts as pending while its input is high. An edge source latches a pending flag on a rising edge.

Software reaches the block through a plain 32-bit register port with separate write and read strobes. Through it, software:
- turns sources on through set registers and off through clear registers;
- gives each source a trigger mode and a priority;
- reads a vector register to learn which source to service;
- writes an end-of-interrupt register when the handler is done.

Among pending, enabled sources the highest priority wins, and a tie goes to the lowest source number. A vector that has been read is held as in service and is not offered again until end-of-interrupt. While it is held, the output is raised only for a source of strictly higher priority. Software clears a latched edge by writing the source's configuration with the edge bit flipped and then writing the original value back. A soft reset returns every register to zero. A global enable gates the output.

Top module: `irqc_top`

## Requirements
- R1: Source n is enabled and disabled through the low registers (0x008 set, 0x010 clear) when n < 32 and through the high registers (0x00C set, 0x014 clear) when n >= 32, at bit n mod 32. Reading either address of a half returns that half's enable bits.
- R2: A write to a set register enables each source whose bit is 1 and leaves the sources whose bit is 0 unchanged.
- R3: A write to a clear register disables each source whose bit is 1 and leaves the others unchanged. A disabled source never wins arbitration.
- R4: Source n has a configuration register at byte address 0x400 + 8*n. Bit 8 selects edge mode (1) or level mode (0), and bits 3:0 hold the priority. The register reads back as written.
- R5: A level source is pending while its input is high. An edge source becomes pending on a rising input edge and stays pending after the input falls. Both take effect within four clocks of the input change.
- R6: A configuration write whose edge bit differs from the stored value clears that source's latched edge.
- R7: Reading the vector register (0x018) returns the enabled, pending source of highest priority, with ties going to the lowest number. It returns 64 when no source qualifies.
- R8: A vector read that returns a source puts that source in service. While a source is in service it is not offered again. The vector reads 64 and the output stays low unless another source of strictly higher priority is pending, in which case that source is offered and the in-service record is left unchanged.
- R9: A write of any value to the end-of-interrupt register (0x01C) ends the in-service state.
- R10: The interrupt output is high only while bit 0 of the global-enable register (0x004) is set and a source is offered.
- R11: Writing 1 to bit 0 of the reset register (0x000) clears all enables, all configurations, the global enable, all edge latches and the in-service state. Hardware reset leaves the same state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a vector read has a side effect) |
| addr | input | ADDR_W (12) | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle rd_en is high |
| irq_in | input | N_SRC (64) | Raw interrupt request lines |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
Arbitration is exercised with several patterns:
- one level source alone, which shows that the global enable gates the output;
- two equal-priority level sources, which shows the tie going to the lower number;
- a strictly higher source arriving during service, which shows preemption apart from plain masking.

A short edge pulse shows that the latch outlives its input and survives end-of-interrupt. The edge-bit toggle then shows it being cleared. Set and clear writes with mixed bit patterns separate write-one semantics from plain register writes. A soft reset taken while an input is still high shows that state is cleared but synchronised inputs are not lost.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam logic [31:0] A_RST  = 32'h000;
   localparam logic [31:0] A_GEN  = 32'h004;
   localparam logic [31:0] A_SETL = 32'h008;
   localparam logic [31:0] A_SETH = 32'h00C;
   localparam logic [31:0] A_CLRL = 32'h010;
   localparam logic [31:0] A_CLRH = 32'h014;
   localparam logic [31:0] A_VEC  = 32'h018;
   localparam logic [31:0] A_EOI  = 32'h01C;
   localparam logic [31:0] A_CFG  = 32'h400;
   localparam int CFG_EDGE_BIT    = 8;

   typedef enum logic [3:0] {
      OP_NONE, OP_RST, OP_GEN, OP_SETL, OP_SETH,
      OP_CLRL, OP_CLRH, OP_VEC, OP_EOI, OP_CFG
   } op_e;

   function automatic op_e decode(input logic [31:0] a, input int n_src);
      op_e r;
      case (a)
         A_RST:   r = OP_RST;
         A_GEN:   r = OP_GEN;
         A_SETL:  r = OP_SETL;
         A_SETH:  r = OP_SETH;
         A_CLRL:  r = OP_CLRL;
         A_CLRH:  r = OP_CLRH;
         A_VEC:   r = OP_VEC;
         A_EOI:   r = OP_EOI;
         default: r = (a >= A_CFG && a < A_CFG + 32'(8 * n_src) && a[2:0] == 3'b000)
                      ? OP_CFG : OP_NONE;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/irqc_source.sv
module irqc_source #(
   parameter int PRIO_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_clr,
   input  logic              en_set,
   input  logic              en_clr,
   input  logic              cfg_we,
   input  logic              cfg_edge_wr,
   input  logic [PRIO_W-1:0] cfg_prio_wr,
   input  logic              raw,
   output logic              enabled,
   output logic              edge_mode,
   output logic [PRIO_W-1:0] prio,
   output logic              req
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   edge_lat;
   logic                   synced;
   logic                   rise;
   logic                   edge_flip;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q <= '0;
            else        sync_q <= raw;
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      end
   endgenerate

   assign synced    = sync_q[SYNC_STAGES-1];
   assign rise      = synced & ~prev_q;
   assign edge_flip = cfg_we && (cfg_edge_wr != edge_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q    <= 1'b0;
         edge_lat  <= 1'b0;
         enabled   <= 1'b0;
         edge_mode <= 1'b0;
         prio      <= '0;
      end else begin
         prev_q <= synced;
         if (soft_clr || edge_flip) edge_lat <= 1'b0;
         else if (rise)             edge_lat <= 1'b1;
         if (soft_clr) begin
            enabled   <= 1'b0;
            edge_mode <= 1'b0;
            prio      <= '0;
         end else begin
            if (en_set)      enabled <= 1'b1;
            else if (en_clr) enabled <= 1'b0;
            if (cfg_we) begin
               edge_mode <= cfg_edge_wr;
               prio      <= cfg_prio_wr;
            end
         end
      end
   end

   assign req = enabled & (edge_mode ? edge_lat : synced);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
   parameter int N_SRC  = 64,
   parameter int PRIO_W = 4,
   localparam int ID_W  = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0]             req,
   input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
   output logic                         valid,
   output logic [ID_W-1:0]              id,
   output logic [PRIO_W-1:0]            win_prio
);
   always_comb begin
      valid    = 1'b0;
      id       = '0;
      win_prio = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (req[i] && (!valid || prio[i] > win_prio)) begin
            valid    = 1'b1;
            id       = ID_W'(i);
            win_prio = prio[i];
         end
      end
   end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
   import irqc_pkg::*;
#(
   parameter int N_SRC       = 64,
   parameter int PRIO_W      = 4,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic [N_SRC-1:0]  irq_in,
   output logic              irq_out
);
   localparam int ID_W  = $clog2(N_SRC);
   localparam int VEC_W = ID_W + 1;
   localparam logic [VEC_W-1:0] NONE = VEC_W'(1) << ID_W;

   generate
      if (N_SRC < 2 || N_SRC > 64) begin : g_bad_nsrc
         $error("irqc_top: N_SRC must be within 2..64");
      end
      if (PRIO_W < 1 || PRIO_W > CFG_EDGE_BIT) begin : g_bad_prio
         $error("irqc_top: PRIO_W must be within 1..8");
      end
      if (ADDR_W < 11 || ADDR_W > 32) begin : g_bad_addr
         $error("irqc_top: ADDR_W must be within 11..32");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("irqc_top: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [31:0]  addr32;
   op_e          op;
   logic         soft_clr;
   logic [31:0]  cfg_off;
   logic [ID_W-1:0] cfg_idx;

   assign addr32   = 32'(addr);
   assign op       = decode(addr32, N_SRC);
   assign soft_clr = wr_en && op == OP_RST && wdata[0];
   assign cfg_off  = addr32 - A_CFG;
   assign cfg_idx  = cfg_off[ID_W+2:3];

   logic [N_SRC-1:0]             en_vec;
   logic [N_SRC-1:0]             edge_vec;
   logic [N_SRC-1:0][PRIO_W-1:0] prio_vec;
   logic [N_SRC-1:0]             req_vec;

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_src
         localparam op_e SET_OP = (i < 32) ? OP_SETL : OP_SETH;
         localparam op_e CLR_OP = (i < 32) ? OP_CLRL : OP_CLRH;
         logic set_i, clr_i, cfg_i;
         assign set_i = wr_en && op == SET_OP && wdata[i % 32];
         assign clr_i = wr_en && op == CLR_OP && wdata[i % 32];
         assign cfg_i = wr_en && op == OP_CFG && cfg_idx == ID_W'(i);
         irqc_source #(.PRIO_W(PRIO_W), .SYNC_STAGES(SYNC_STAGES)) u_src (
            .clk         (clk),
            .rst_n       (rst_n),
            .soft_clr    (soft_clr),
            .en_set      (set_i),
            .en_clr      (clr_i),
            .cfg_we      (cfg_i),
            .cfg_edge_wr (wdata[CFG_EDGE_BIT]),
            .cfg_prio_wr (wdata[PRIO_W-1:0]),
            .raw         (irq_in[i]),
            .enabled     (en_vec[i]),
            .edge_mode   (edge_vec[i]),
            .prio        (prio_vec[i]),
            .req         (req_vec[i])
         );
      end
   endgenerate

   logic              in_svc;
   logic [ID_W-1:0]   svc_id;
   logic [PRIO_W-1:0] svc_prio;
   logic [N_SRC-1:0]  req_m;
   logic              cand_valid;
   logic [ID_W-1:0]   cand_id;
   logic [PRIO_W-1:0] cand_prio;
   logic              pres_valid;
   logic [VEC_W-1:0]  vec_val;

   assign req_m = req_vec & ~(in_svc ? (N_SRC'(1) << svc_id) : '0);

   irqc_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
      .req      (req_m),
      .prio     (prio_vec),
      .valid    (cand_valid),
      .id       (cand_id),
      .win_prio (cand_prio)
   );

   assign pres_valid = cand_valid && (!in_svc || cand_prio > svc_prio);
   assign vec_val    = pres_valid ? VEC_W'(cand_id) : NONE;

   logic gen_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_en   <= 1'b0;
         in_svc   <= 1'b0;
         svc_id   <= '0;
         svc_prio <= '0;
      end else if (soft_clr) begin
         gen_en   <= 1'b0;
         in_svc   <= 1'b0;
         svc_id   <= '0;
         svc_prio <= '0;
      end else begin
         if (wr_en && op == OP_GEN) gen_en <= wdata[0];
         if (wr_en && op == OP_EOI) begin
            in_svc <= 1'b0;
         end else if (rd_en && op == OP_VEC && pres_valid && !in_svc) begin
            in_svc   <= 1'b1;
            svc_id   <= cand_id;
            svc_prio <= cand_prio;
         end
      end
   end

   assign irq_out = gen_en && pres_valid;

   logic [63:0] en_pad;
   assign en_pad = 64'(en_vec);

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (op)
            OP_GEN:           rdata = {31'b0, gen_en};
            OP_SETL, OP_CLRL: rdata = en_pad[31:0];
            OP_SETH, OP_CLRH: rdata = en_pad[63:32];
            OP_VEC:           rdata = 32'(vec_val);
            OP_CFG: begin
               rdata[CFG_EDGE_BIT] = edge_vec[cfg_idx];
               rdata[PRIO_W-1:0]   = prio_vec[cfg_idx];
            end
            default:          rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
   import irqc_pkg::*;
#(
   parameter int N_SRC  = 64,
   parameter int ADDR_W = 12,
   localparam int ID_W  = $clog2(N_SRC)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       wdata,
   input logic [31:0]       rdata,
   input logic              irq_out,
   input logic [N_SRC-1:0]  en_vec,
   input logic              in_svc,
   input logic [ID_W-1:0]   svc_id,
   input logic              cand_valid,
   input logic [ID_W-1:0]   cand_id,
   input logic [N_SRC-1:0]  req_m,
   input logic              gen_en
);
   logic [31:0] a32;
   logic [63:0] en_pad;
   logic [31:0] en_lo;
   assign a32    = 32'(addr);
   assign en_pad = 64'(en_vec);
   assign en_lo  = en_pad[31:0];

   a_r2_set_ones_only: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && a32 == A_SETL) |=> en_lo == ($past(en_lo) | $past(wdata)));

   a_r3_clear_ones_only: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && a32 == A_CLRL) |=> en_lo == ($past(en_lo) & ~$past(wdata)));

   a_r7_winner_is_request: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid |-> req_m[cand_id]);

   a_r7_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && a32 == A_VEC && gen_en && !irq_out) |-> rdata == 32'(1 << ID_W));

   a_r8_service_held: assert property (@(posedge clk) disable iff (!rst_n)
      (in_svc && !(wr_en && (a32 == A_EOI || a32 == A_RST))) |=> (in_svc && $stable(svc_id)));

   a_r9_eoi_ends_service: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && a32 == A_EOI) |=> !in_svc);

   a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && a32 == A_RST && wdata[0]) |=> (en_vec == '0 && !gen_en && !in_svc && !irq_out));
endmodule

bind irqc_top irqc_checker #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .addr       (addr),
   .wdata      (wdata),
   .rdata      (rdata),
   .irq_out    (irq_out),
   .en_vec     (en_vec),
   .in_svc     (in_svc),
   .svc_id     (svc_id),
   .cand_valid (cand_valid),
   .cand_id    (cand_id),
   .req_m      (req_m),
   .gen_en     (gen_en)
);

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [63:0] src = '0;
   logic        irq_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   irqc_top uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_in(src), .irq_out(irq_out)
   );

   localparam logic [11:0] RST = 12'h000, GEN = 12'h004, SETL = 12'h008, SETH = 12'h00C,
                           CLRL = 12'h010, CLRH = 12'h014, VEC = 12'h018, EOI = 12'h01C;

   function automatic logic [11:0] cfg_a(input int n);
      return 12'(32'h400 + n * 8);
   endfunction

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   // driver: pushes the expected value, then performs the read
   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
      @(posedge clk); #1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      rd_en = 1'b1; addr = a;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      @(negedge clk);
      checks++;
      if (irq_out !== e) begin
         errors++;
         $display("FAIL %s irq_out actual %0b expected %0b", tag, irq_out, e);
      end
   endtask

   // monitor: pops and compares while the read is in flight
   always @(negedge clk) begin
      if (rd_en) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard read with no expectation actual %h expected none", rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rdata !== e) begin
               errors++;
               $display("FAIL %s addr %h actual %h expected %h", t, addr, rdata, e);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // reset state (R11)
      rd(GEN, 32'd0, "R11 reset gen");
      rd(SETL, 32'd0, "R11 reset enables");
      rd(VEC, 32'd64, "R7 idle vector");
      chk_irq(1'b0, "R10 reset output");
      // enables (R1, R2, R3)
      wr(SETL, 32'h5);
      rd(SETL, 32'h5, "R2 set");
      wr(SETL, 32'h2);
      rd(CLRL, 32'h7, "R2 zero bits keep");
      wr(CLRL, 32'h4);
      rd(SETL, 32'h3, "R3 clear");
      wr(SETH, 32'h8000_0001);
      rd(CLRH, 32'h8000_0001, "R1 high half");
      // configuration (R4)
      wr(cfg_a(0), 32'h002);
      wr(cfg_a(1), 32'h105);
      wr(cfg_a(32), 32'h002);
      wr(cfg_a(63), 32'h007);
      rd(cfg_a(1), 32'h105, "R4 cfg readback");
      rd(cfg_a(63), 32'h007, "R4 cfg readback hi");
      // level source, output gated (R5, R10, R8, R9)
      src[0] = 1'b1;
      idle(4);
      chk_irq(1'b0, "R10 gated without global enable");
      rd(VEC, 32'd0, "R5 level pending");
      rd(VEC, 32'd64, "R8 in service not re-offered");
      wr(GEN, 32'h1);
      chk_irq(1'b0, "R8 output low during service");
      wr(EOI, 32'hDEAD_BEEF);
      chk_irq(1'b1, "R9 eoi releases");
      // tie (R7)
      src[32] = 1'b1;
      idle(4);
      rd(VEC, 32'd0, "R7 tie lowest number");
      rd(VEC, 32'd64, "R8 equal priority no preempt");
      chk_irq(1'b0, "R8 equal priority output low");
      // preempt (R8)
      src[63] = 1'b1;
      idle(4);
      chk_irq(1'b1, "R8 strictly higher raises output");
      rd(VEC, 32'd63, "R8 higher offered");
      wr(EOI, 32'h0);
      rd(VEC, 32'd63, "R7 highest priority");
      wr(EOI, 32'h0);
      src[63] = 1'b0;
      idle(4);
      // edge source (R5, R6)
      src[1] = 1'b1;
      idle(2);
      src[1] = 1'b0;
      idle(5);
      rd(VEC, 32'd1, "R5 edge latched after input fell");
      wr(EOI, 32'h0);
      rd(VEC, 32'd1, "R5 latch survives eoi");
      wr(EOI, 32'h0);
      wr(cfg_a(1), 32'h005);
      wr(cfg_a(1), 32'h105);
      rd(VEC, 32'd0, "R6 toggle clears latch");
      wr(EOI, 32'h0);
      // disabled source loses (R3)
      wr(CLRL, 32'h1);
      rd(VEC, 32'd32, "R3 disabled never wins");
      wr(EOI, 32'h0);
      // level drop (R5)
      src[0] = 1'b0;
      src[32] = 1'b0;
      idle(4);
      rd(VEC, 32'd64, "R5 level released");
      chk_irq(1'b0, "R10 nothing offered");
      // soft reset (R11)
      src[32] = 1'b1;
      idle(4);
      wr(RST, 32'h1);
      rd(GEN, 32'd0, "R11 gen cleared");
      rd(SETH, 32'd0, "R11 enables cleared");
      rd(cfg_a(63), 32'd0, "R11 cfg cleared");
      rd(VEC, 32'd64, "R11 nothing enabled");
      chk_irq(1'b0, "R11 output low");
      wr(SETH, 32'h1);
      rd(VEC, 32'd32, "R11 input still seen after soft reset");
      chk_irq(1'b0, "R10 global enable cleared");
      idle(2);
      if (exp_q.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL scoreboard leftover actual %0d expected 0", exp_q.size());
      end
      finish_run();
   end
endmodule